// File: doc/BRIEF.md
# Interleaved Dual-Channel Serial Word FIFO

This block sits between a two-lane serial port (a primary lane and a secondary lane) and the word interface of a processor. A single store of eight 16-bit entries is shared by both lanes. How many words it can hold depends on two settings: the configured serial word length and whether the secondary lane is in use. With the secondary lane on, the serial side writes one primary word and one secondary word together, and they are stored back to back with the primary word first. A word longer than 16 bits occupies two consecutive entries, low half first. The processor always reads it back as one 32-bit value.

Configuration is copied from the inputs only while the port is disabled. Disabling the port also empties the store and clears the overflow flag. While the port is enabled, the copied configuration stays fixed. The processor side reads the head word combinationally and removes it with a pop strobe. A flag marks whether the head word belongs to the secondary lane.

Top module: `ilv_sfifo`

## Requirements
- R1: After reset the FIFO is empty (`empty`=1), `full`=0 and `overflow`=0. The captured configuration is a 16-bit word length with the secondary lane off.
- R2: `cfg_wlen` and `cfg_dual` are captured on every clock edge where `port_en`=0, and are ignored while `port_en`=1. A clock edge with `port_en`=0 empties the FIFO, clears `overflow`, and ignores any push or pop.
- R3: With a word length of at most 16 bits and the secondary lane off, the FIFO holds 8 words and returns them in the order they were pushed, zero-extended to 32 bits.
- R4: With a word length above 16 bits and the secondary lane off, the FIFO holds 4 words, and each word is returned whole as a 32-bit `pop_data`.
- R5: With a word length of at most 16 bits and the secondary lane on, one push stores `push_pri` and then `push_sec`. The FIFO holds 4 such pairs, and `pop_is_sec` is 0 for each primary word and 1 for each secondary word.
- R6: With a word length above 16 bits and the secondary lane on, the FIFO holds 2 pairs, returned in the order primary then secondary as 32-bit words.
- R7: `full` is 1 exactly when one more push would exceed the capacity of the current mode. A push while `full` is dropped and sets `overflow`, which stays set until the port is disabled.
- R8: `cfg_wlen` holds the word length minus one. Values 0 and 1 are treated as 2, so the shortest word is 3 bits. Data bits at or above the word length are cleared on push.
- R9: A pop while `empty` has no effect. A push and a pop in the same cycle both take effect, with `full` judged on the state before the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; configuration is captured only while 0 |
| cfg_wlen | input | 5 | Word length minus one |
| cfg_dual | input | 1 | Secondary lane in use |
| push_valid | input | 1 | Serial side writes a word (or a pair, when the secondary lane is on) |
| push_pri | input | 32 | Primary lane word |
| push_sec | input | 32 | Secondary lane word |
| full | output | 1 | The next push would not fit |
| pop_ready | input | 1 | Processor removes the head word |
| empty | output | 1 | No word stored |
| pop_data | output | 32 | Head word |
| pop_is_sec | output | 1 | Head word belongs to the secondary lane |
| overflow | output | 1 | Sticky flag: a push was dropped |

## Verification
The store is tried in all four partitions: narrow or wide words, with the secondary lane off or on. Each partition is filled to its boundary, which shows whether the capacity (8, 4 or 2 words per lane) and the point where `full` rises are right. Short word lengths with high input bits set show whether data is masked to the word length, including the clamp of the shortest setting. Wide words whose two halves differ expose a swapped or lost half. A long random mix of pushes, pops and reconfigurations, checked against a queue model every clock, covers simultaneous push and pop, pops while empty, and any desynchronisation of the primary/secondary tag.

// File: rtl/ilv_sfifo.sv
module ilv_sfifo #(
  parameter int EW    = 16,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            port_en,
  input  logic [4:0]      cfg_wlen,
  input  logic            cfg_dual,
  input  logic            push_valid,
  input  logic [2*EW-1:0] push_pri,
  input  logic [2*EW-1:0] push_sec,
  output logic            full,
  input  logic            pop_ready,
  output logic            empty,
  output logic [2*EW-1:0] pop_data,
  output logic            pop_is_sec,
  output logic            overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int WW = 2 * EW;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count, epw, per_push;
  logic [4:0]    wlen_q;
  logic          dual_q, tog, wide, do_push, do_pop;
  logic [WW-1:0] mask, pri_m, sec_m;
  logic [EW-1:0] slot [4];

  assign wide     = (wlen_q >= 5'(EW));
  assign epw      = (AW+1)'(wide ? 2 : 1);
  assign per_push = dual_q ? (epw << 1) : epw;
  assign empty    = (count == '0);
  assign full     = ({1'b0, count} + {1'b0, per_push}) > (AW+2)'(DEPTH);
  assign do_push  = port_en && push_valid && !full;
  assign do_pop   = port_en && pop_ready && !empty;

  assign mask  = {WW{1'b1}} >> (5'd31 - wlen_q);
  assign pri_m = push_pri & mask;
  assign sec_m = push_sec & mask;

  always_comb begin
    if (wide) begin
      slot[0] = pri_m[EW-1:0];
      slot[1] = pri_m[WW-1:EW];
      slot[2] = sec_m[EW-1:0];
      slot[3] = sec_m[WW-1:EW];
    end else begin
      slot[0] = pri_m[EW-1:0];
      slot[1] = sec_m[EW-1:0];
      slot[2] = '0;
      slot[3] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push)
      for (int k = 0; k < 4; k++)
        if (k < int'(per_push))
          mem[wr_ptr + AW'(k)] <= slot[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
      tog      <= 1'b0;
      wlen_q   <= 5'd15;
      dual_q   <= 1'b0;
    end else if (!port_en) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
      tog      <= 1'b0;
      wlen_q   <= (cfg_wlen < 5'd2) ? 5'd2 : cfg_wlen;
      dual_q   <= cfg_dual;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(per_push);
      if (do_pop) begin
        rd_ptr <= rd_ptr + AW'(epw);
        tog    <= ~tog;
      end
      count <= count + (do_push ? per_push : (AW+1)'(0)) - (do_pop ? epw : (AW+1)'(0));
      if (push_valid && full) overflow <= 1'b1;
    end
  end

  assign pop_data   = wide ? {mem[rd_ptr + AW'(1)], mem[rd_ptr]} : {{EW{1'b0}}, mem[rd_ptr]};
  assign pop_is_sec = dual_q & tog;
endmodule

// File: rtl/ilv_sfifo_chk.sv
module ilv_sfifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       port_en,
  input logic       push_valid,
  input logic       pop_ready,
  input logic       full,
  input logic       empty,
  input logic       overflow,
  input logic       pop_is_sec,
  input logic       dual_q,
  input logic [4:0] wlen_q
);
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R7
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && push_valid && full) |=> overflow); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && overflow) |=> overflow); // R7
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |=> ($stable(wlen_q) && $stable(dual_q))); // R2
  AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (empty && !overflow)); // R2
  AST_LANE_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && dual_q && pop_ready && !empty) |=> (pop_is_sec != $past(pop_is_sec))); // R5
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && empty && !push_valid) |=> empty); // R9
endmodule

bind ilv_sfifo ilv_sfifo_chk u_chk (.*);

// File: tb/ilv_sfifo_bench.sv
module ilv_sfifo_bench;
  logic clk = 0, rst_n = 0, port_en = 0, cfg_dual = 0, push_valid = 0, pop_ready = 0;
  logic [4:0]  cfg_wlen = 5'd15;
  logic [31:0] push_pri = 0, push_sec = 0;
  logic full, empty, pop_is_sec, overflow;
  logic [31:0] pop_data;

  ilv_sfifo u_ilv_sfifo (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  logic [31:0] mq[$];
  bit ms[$];
  int m_wlen = 15;
  bit m_dual = 0, m_ovf = 0;
  string rq = "R1";

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog expired: actual=%0d expected<100000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  function automatic int epw_m();
    return (m_wlen >= 16) ? 2 : 1;
  endfunction
  function automatic int per_m();
    return epw_m() * (m_dual ? 2 : 1);
  endfunction
  function automatic bit full_m();
    return (mq.size() * epw_m() + per_m()) > 8;
  endfunction
  function automatic logic [31:0] mask_m();
    return (m_wlen == 31) ? 32'hFFFF_FFFF : ((32'h1 << (m_wlen + 1)) - 1);
  endfunction

  task automatic compare();
    chk(rq, "empty", 32'(empty), 32'(mq.size() == 0));
    chk(rq, "full", 32'(full), 32'(full_m()));
    chk(rq, "overflow", 32'(overflow), 32'(m_ovf));
    if (mq.size() > 0) begin
      chk(rq, "pop_data", pop_data, mq[0]);
      chk(rq, "pop_is_sec", 32'(pop_is_sec), 32'(ms[0]));
    end
  endtask

  task automatic cyc(bit pe, bit pv, logic [31:0] pp, logic [31:0] ps, bit pr);
    bit fpre;
    port_en = pe; push_valid = pv; push_pri = pp; push_sec = ps; pop_ready = pr;
    if (!pe) begin
      mq.delete(); ms.delete(); m_ovf = 0;
      m_wlen = (cfg_wlen < 2) ? 2 : int'(cfg_wlen);
      m_dual = cfg_dual;
    end else begin
      fpre = full_m();
      if (pr && mq.size() > 0) begin
        void'(mq.pop_front()); void'(ms.pop_front());
      end
      if (pv && fpre) m_ovf = 1;
      if (pv && !fpre) begin
        mq.push_back(pp & mask_m()); ms.push_back(0);
        if (m_dual) begin
          mq.push_back(ps & mask_m()); ms.push_back(1);
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic configure(logic [4:0] wl, bit dual);
    cfg_wlen = wl; cfg_dual = dual;
    cyc(0, 0, 0, 0, 0);
  endtask

  task automatic fill_drain(int n, logic [31:0] seed);
    for (int i = 0; i < n; i++)
      cyc(1, 1, seed + 32'(i) * 32'h0101_0101, ~seed ^ 32'(i * 7), 0);
    for (int i = 0; i < 2 * n; i++) cyc(1, 0, 0, 0, 1);
  endtask

  initial begin
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset empty", 32'(empty), 1);
    chk("R1", "reset full", 32'(full), 0);
    chk("R1", "reset overflow", 32'(overflow), 0);
    chk("R1", "reset mode capacity", 32'(u_ilv_sfifo.full), 0);

    rq = "R3"; configure(5'd15, 0); fill_drain(8, 32'h1234_5678);
    rq = "R7"; fill_drain(9, 32'hAAAA_5555);
    chk("R7", "overflow sticky after drain", 32'(overflow), 1);
    rq = "R2"; configure(5'd15, 0);
    chk("R2", "disable clears overflow", 32'(overflow), 0);

    rq = "R4"; configure(5'd23, 0); fill_drain(5, 32'hDEAD_BEEF);
    configure(5'd31, 0); fill_drain(4, 32'hF00D_CAFE);
    rq = "R5"; configure(5'd15, 1); fill_drain(5, 32'h0BAD_F00D);
    rq = "R6"; configure(5'd31, 1); fill_drain(3, 32'h8765_4321);
    rq = "R8"; configure(5'd7, 0); fill_drain(3, 32'hFFFF_FFFF);
    configure(5'd0, 1); fill_drain(2, 32'hFFFF_FFF5);
    configure(5'd16, 0); fill_drain(2, 32'hFFFF_FFFF);

    rq = "R2"; configure(5'd15, 0);
    cyc(1, 1, 32'h11, 32'h22, 0);
    cfg_wlen = 5'd31; cfg_dual = 1;
    cyc(1, 1, 32'h3_0033, 32'h44, 0);
    cyc(1, 0, 0, 0, 1);
    cyc(1, 1, 32'h55, 32'h66, 0);
    cyc(0, 1, 32'h77, 32'h88, 1);
    chk("R2", "disable flushes", 32'(empty), 1);

    rq = "R9"; configure(5'd15, 1);
    cyc(1, 0, 0, 0, 1);
    chk("R9", "pop on empty", 32'(empty), 1);
    for (int i = 0; i < 4; i++) cyc(1, 1, 32'(i), 32'(i + 100), 0);
    cyc(1, 1, 32'h9, 32'h10, 1);
    for (int i = 0; i < 3000; i++) begin
      if (i % 300 == 299) configure(5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)));
      cyc(1, 1'($urandom_range(0, 1)), $urandom, $urandom, 1'($urandom_range(0, 1)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule